// File: doc/BRIEF.md
# SD/MMC Command Path Controller

This block drives the command line of an SD or MMC card. Software loads a 32-bit argument, then writes a command word that carries a 6-bit command index, a two-bit field choosing what kind of reply to expect, and an enable bit. The block then serializes a 48-bit frame onto the command line, one bit per clock, and, if a reply is expected, listens for it for a bounded number of cycles. It captures either a 32-bit short reply or a 128-bit long reply into four response words, checks the CRC7 of short replies when asked to, and raises sticky status flags for "sent", "reply complete", "reply CRC bad" and "no reply".

After a short reply the block can also watch data line 0. A card signals that it is busy by holding that line low. When the data timer register is nonzero and the command does not announce a data transfer, the block waits for the line to return high and flags that event, or flags a data timeout if the timer runs out first. Command bits that belong to other parts of the controller (data transfer, stop, and the rest) are stored and read back unchanged.

Registers sit on a simple word-addressed port with a combinational read. The status address reads the flags and accepts write-one-to-clear writes.

Top module: `sdc_cmd_path`

## Requirements
- R1: After reset every register reads zero, `cmd_oe` is low and `cmd_out` is high.
- R2: Writing the command register (address 1) with bit 12 set, while the stored bit 12 is clear, sends 48 bits MSB first, one per clock, starting in the cycle after the write edge: a 0, a 1, index bits 5:0, the argument (address 0), CRC7 (polynomial x^7+x^3+1 over the first 40 bits), and a closing 1. `cmd_oe` is high for exactly those 48 cycles.
- R3: With reply field bits 9:8 = 00, status bit 7 reads 1 from 48 cycles after the write edge, and not before.
- R4: With a reply expected, the line is sampled for a 0 start bit for 64 cycles after the closing bit. If none comes, status bit 2 reads 1 from 64 cycles after the last sampled cycle of the frame (112 after the write edge), and not one cycle before.
- R5: Reply field 01 expects a 48-bit reply. Its bits 39:8 (counted from the closing bit as bit 0) land in response word 0 (address 2). If the CRC7 over its first 40 bits equals bits 7:1, status bit 6 is set; otherwise status bit 0 is set instead. The flag appears one cycle after the closing bit is sampled.
- R6: Reply field 10 expects a 48-bit reply without the CRC check: status bit 6 is set whatever bits 7:1 hold.
- R7: Reply field 11 expects a 136-bit reply. The 128 bits after its first 8 fill addresses 2 to 5, the earliest received word in address 2, and status bit 6 is set with no CRC check.
- R8: After a successful short reply, when the data timer (address 6) is nonzero, command bit 6 is clear and data line 0 is low, status bit 20 reads 1 while the line stays low. When it goes high, status bit 21 is set and bit 20 returns to 0. With command bit 6 set no busy wait happens.
- R9: If data line 0 stays low for as many cycles as the data timer holds, status bit 3 is set instead of bit 21 and bit 20 returns to 0.
- R10: Writing address 7 clears each status flag whose bit is 1 in the written word, for bits 11:0 and 28:21; other flags stay set.
- R11: Status bit 13 reads 1 from the start of a command until it ends with one of its final flags.
- R12: While the stored command enable bit is set, a nonzero write to address 1 is ignored (readback unchanged, nothing sent). A zero write clears the register and abandons any command in flight, releasing the line at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one card-line bit per cycle |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Word address: 0 argument, 1 command, 2-5 responses, 6 data timer, 7 status/clear |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational) |
| cmd_out | output | 1 | Command line output value |
| cmd_oe | output | 1 | Command line drive enable |
| cmd_in | input | 1 | Command line input value |
| d0_in | input | 1 | Data line 0 level |

## Verification
Frame bit k is on the line k cycles after the write edge, the sent flag is due at 48 cycles and the no-reply flag at 112, a reply flag one cycle after its closing bit is sampled, and a busy-timeout flag as many cycles after the reply flag as the timer holds. The bench counts falling edges from each write and reads the status on the cycle a result is due and on the cycle before, so a flag that is early or late by one cycle is caught. Replies and expected CRC values are built in the bench by polynomial long division, and the command index is swept over all 64 values.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  // frame and reply lengths in line bits
  localparam int unsigned FRM_BITS  = 48;
  localparam int unsigned RX_SHORT  = 47;   // bits after the start bit, short reply
  localparam int unsigned RX_LONG   = 135;  // bits after the start bit, long reply
  localparam int unsigned RSP_BITS  = 128;

  // command register bits
  localparam int unsigned CB_DATA = 6;
  localparam int unsigned CB_EN   = 12;

  // status bit positions
  localparam int unsigned ST_CRCBAD = 0;
  localparam int unsigned ST_CTMO   = 2;
  localparam int unsigned ST_DTMO   = 3;
  localparam int unsigned ST_REND   = 6;
  localparam int unsigned ST_SENT   = 7;
  localparam int unsigned ST_ACTIVE = 13;
  localparam int unsigned ST_BUSY   = 20;
  localparam int unsigned ST_BEND   = 21;
  localparam logic [31:0] CLR_MASK  = 32'h1FE0_0FFF;

  // register addresses
  localparam logic [2:0] A_ARG  = 3'd0;
  localparam logic [2:0] A_CMD  = 3'd1;
  localparam logic [2:0] A_RSP0 = 3'd2;
  localparam logic [2:0] A_RSP1 = 3'd3;
  localparam logic [2:0] A_RSP2 = 3'd4;
  localparam logic [2:0] A_RSP3 = 3'd5;
  localparam logic [2:0] A_DTMR = 3'd6;
  localparam logic [2:0] A_STAT = 3'd7;

  typedef enum logic [1:0] {RW_NONE, RW_SHORT_CRC, RW_SHORT_RAW, RW_LONG} rwait_t;
  typedef enum logic [2:0] {S_IDLE, S_TX, S_WAIT, S_RX, S_BUSY} cst_t;

  // CRC7, x^7 + x^3 + 1, shifted in MSB first
  function automatic logic [6:0] crc7_of(input logic [39:0] d);
    logic [6:0] c;
    logic fb;
    c = '0;
    for (int i = 39; i >= 0; i--) begin
      fb = d[i] ^ c[6];
      c  = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction
endpackage

// File: rtl/sdc_cmd_tx.sv
module sdc_cmd_tx #(
  parameter int unsigned LEN = 48
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           abort,
  input  logic [LEN-1:0] frame,
  output logic           line,
  output logic           active,
  output logic           last
);
  localparam int unsigned CW = $clog2(LEN);

  logic [LEN-1:0] sh_q;
  logic [CW-1:0]  cnt_q;
  logic           act_q;

  assign last   = act_q && (cnt_q == CW'(LEN - 1));
  assign active = act_q;
  assign line   = act_q ? sh_q[LEN-1] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (abort) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (load) begin
      sh_q  <= frame;
      cnt_q <= '0;
      act_q <= 1'b1;
    end else if (act_q) begin
      sh_q  <= {sh_q[LEN-2:0], 1'b0};
      cnt_q <= cnt_q + 1'b1;
      if (last) act_q <= 1'b0;
    end
  end
endmodule

// File: rtl/sdc_cmd_rx.sv
module sdc_cmd_rx #(
  parameter int unsigned SHORT_N = 47,
  parameter int unsigned LONG_N  = 135,
  parameter int unsigned KEEP    = 128
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            arm,
  input  logic            long_sel,
  input  logic            abort,
  input  logic            bit_in,
  output logic            done,
  output logic [KEEP-1:0] sr
);
  localparam int unsigned CW = $clog2(LONG_N);

  logic [CW-1:0] cnt_q;
  logic          act_q;
  logic          long_q;
  logic          done_q;
  logic [KEEP-1:0] sr_q;
  logic [CW-1:0] need;

  assign need = long_q ? CW'(LONG_N - 1) : CW'(SHORT_N - 1);
  assign done = done_q;
  assign sr   = sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      act_q  <= 1'b0;
      long_q <= 1'b0;
      done_q <= 1'b0;
      sr_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (abort) begin
        act_q <= 1'b0;
      end else if (arm) begin
        act_q  <= 1'b1;
        cnt_q  <= '0;
        long_q <= long_sel;
      end else if (act_q) begin
        sr_q  <= {sr_q[KEEP-2:0], bit_in};
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == need) begin
          act_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sdc_cmd_path.sv
module sdc_cmd_path
  import sdc_pkg::*;
#(
  parameter int unsigned RSP_TMO = 64,
  parameter int unsigned TMR_W   = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        cmd_out,
  output logic        cmd_oe,
  input  logic        cmd_in,
  input  logic        d0_in
);
  localparam int unsigned WC_W = $clog2(RSP_TMO);

  logic [31:0]      arg_q, cmd_q, flags_q;
  logic [31:0]      rsp_q [4];
  logic [TMR_W-1:0] dtmr_q, tmr_q;
  logic [WC_W-1:0]  wcnt_q;
  cst_t             st_q, st_d;

  // named events, brought out for the checker
  logic ev_sent, ev_rend, ev_crcbad, ev_ctmo, ev_bend, ev_dtmo;
  logic [31:0] set_vec, stat_w;
  logic in_wait;

  logic wr_cmd, cmd_zero, cmd_go, rx_arm, rx_done, tx_last, tx_act;
  logic crc_bad, busy_req, busy_now, active;
  logic [FRM_BITS-1:0] tx_frame;
  logic [RSP_BITS-1:0] rx_sr;
  rwait_t rmode;

  assign wr_cmd   = reg_we && (reg_addr == A_CMD);
  assign cmd_zero = wr_cmd && (reg_wdata == 32'd0);
  assign cmd_go   = wr_cmd && !cmd_q[CB_EN] && reg_wdata[CB_EN];
  assign rmode    = rwait_t'(cmd_q[9:8]);
  assign tx_frame = {2'b01, reg_wdata[5:0], arg_q,
                     crc7_of({2'b01, reg_wdata[5:0], arg_q}), 1'b1};
  assign crc_bad  = crc7_of({1'b0, rx_sr[RX_SHORT-1:8]}) != rx_sr[7:1];
  assign busy_req = ((rmode == RW_SHORT_CRC) || (rmode == RW_SHORT_RAW)) &&
                    !cmd_q[CB_DATA] && (dtmr_q != '0);
  assign busy_now = (st_q == S_BUSY) && !d0_in;
  assign active   = (st_q != S_IDLE);
  assign in_wait  = (st_q == S_WAIT);
  assign cmd_oe   = tx_act;

  sdc_cmd_tx #(.LEN(FRM_BITS)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(cmd_go), .abort(cmd_zero),
    .frame(tx_frame), .line(cmd_out), .active(tx_act), .last(tx_last)
  );

  sdc_cmd_rx #(.SHORT_N(RX_SHORT), .LONG_N(RX_LONG), .KEEP(RSP_BITS)) u_rx (
    .clk(clk), .rst_n(rst_n), .arm(rx_arm), .long_sel(rmode == RW_LONG),
    .abort(cmd_zero), .bit_in(cmd_in), .done(rx_done), .sr(rx_sr)
  );

  always_comb begin
    st_d      = st_q;
    rx_arm    = 1'b0;
    ev_sent   = 1'b0;
    ev_rend   = 1'b0;
    ev_crcbad = 1'b0;
    ev_ctmo   = 1'b0;
    ev_bend   = 1'b0;
    ev_dtmo   = 1'b0;
    case (st_q)
      S_IDLE: if (cmd_go) st_d = S_TX;
      S_TX: if (tx_last) begin
        if (rmode == RW_NONE) begin
          ev_sent = 1'b1;
          st_d    = S_IDLE;
        end else begin
          st_d = S_WAIT;
        end
      end
      S_WAIT: begin
        if (!cmd_in) begin
          rx_arm = 1'b1;
          st_d   = S_RX;
        end else if (wcnt_q == WC_W'(RSP_TMO - 1)) begin
          ev_ctmo = 1'b1;
          st_d    = S_IDLE;
        end
      end
      S_RX: if (rx_done) begin
        if ((rmode == RW_SHORT_CRC) && crc_bad) begin
          ev_crcbad = 1'b1;
          st_d      = S_IDLE;
        end else begin
          ev_rend = 1'b1;
          st_d    = (busy_req && !d0_in) ? S_BUSY : S_IDLE;
        end
      end
      S_BUSY: begin
        if (d0_in) begin
          ev_bend = 1'b1;
          st_d    = S_IDLE;
        end else if (tmr_q == dtmr_q - 1'b1) begin
          ev_dtmo = 1'b1;
          st_d    = S_IDLE;
        end
      end
      default: st_d = S_IDLE;
    endcase
    if (cmd_zero) st_d = S_IDLE;
  end

  always_comb begin
    set_vec            = '0;
    set_vec[ST_CRCBAD] = ev_crcbad;
    set_vec[ST_CTMO]   = ev_ctmo;
    set_vec[ST_DTMO]   = ev_dtmo;
    set_vec[ST_REND]   = ev_rend;
    set_vec[ST_SENT]   = ev_sent;
    set_vec[ST_BEND]   = ev_bend;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      arg_q   <= '0;
      cmd_q   <= '0;
      dtmr_q  <= '0;
      flags_q <= '0;
      wcnt_q  <= '0;
      tmr_q   <= '0;
      for (int k = 0; k < 4; k++) rsp_q[k] <= '0;
    end else begin
      st_q   <= st_d;
      wcnt_q <= (st_q == S_WAIT) ? wcnt_q + 1'b1 : '0;
      tmr_q  <= (st_q == S_BUSY) ? tmr_q + 1'b1 : '0;
      if (reg_we && reg_addr == A_ARG)  arg_q  <= reg_wdata;
      if (reg_we && reg_addr == A_DTMR) dtmr_q <= reg_wdata[TMR_W-1:0];
      if (cmd_zero || cmd_go || (wr_cmd && !cmd_q[CB_EN])) cmd_q <= reg_wdata;
      if (reg_we && reg_addr == A_STAT)
        flags_q <= (flags_q & ~(reg_wdata & CLR_MASK)) | set_vec;
      else
        flags_q <= flags_q | set_vec;
      if ((st_q == S_RX) && rx_done) begin
        if (rmode == RW_LONG) begin
          for (int k = 0; k < 4; k++)
            rsp_q[k] <= rx_sr[RSP_BITS-1-32*k -: 32];
        end else begin
          rsp_q[0] <= rx_sr[39:8];
        end
      end
    end
  end

  assign stat_w = flags_q | (32'(busy_now) << ST_BUSY) | (32'(active) << ST_ACTIVE);

  always_comb begin
    case (reg_addr)
      A_ARG:   reg_rdata = arg_q;
      A_CMD:   reg_rdata = cmd_q;
      A_RSP0:  reg_rdata = rsp_q[0];
      A_RSP1:  reg_rdata = rsp_q[1];
      A_RSP2:  reg_rdata = rsp_q[2];
      A_RSP3:  reg_rdata = rsp_q[3];
      A_DTMR:  reg_rdata = 32'(dtmr_q);
      default: reg_rdata = stat_w;
    endcase
  end
endmodule

// File: rtl/sdc_cmd_path_chk.sv
module sdc_cmd_path_chk #(
  parameter int unsigned RSP_TMO = 64
) (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_we,
  input logic [2:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic        cmd_oe,
  input logic        cmd_out,
  input logic        d0_in,
  input logic [31:0] status,
  input logic [31:0] cmd_reg,
  input logic        in_wait,
  input logic [31:0] set_vec
);
  localparam logic [31:0] CLRM = 32'h1FE0_0FFF;
  int unsigned wait_cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wait_cyc <= 0;
    else        wait_cyc <= in_wait ? wait_cyc + 1 : 0;
  end

  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_oe) |-> !cmd_out);                                          // R2
  AST_OE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_oe |-> status[13]);                                               // R11
  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(set_vec));                                                   // R5
  AST_TMO_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    set_vec[2] |-> (wait_cyc == RSP_TMO - 1));                            // R4
  AST_BUSY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    status[20] |-> !d0_in);                                               // R8
  AST_DTMO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    set_vec[3] |-> !d0_in);                                               // R9
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 3'd7) |=>
      ((status & $past(reg_wdata & CLRM & ~set_vec)) == 32'd0));          // R10
  AST_IGNORED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 3'd1 && cmd_reg[12] && reg_wdata != 32'd0) |=>
      $stable(cmd_reg));                                                  // R12
endmodule

bind sdc_cmd_path sdc_cmd_path_chk #(.RSP_TMO(RSP_TMO)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .cmd_oe(cmd_oe), .cmd_out(cmd_out), .d0_in(d0_in),
  .status(stat_w), .cmd_reg(cmd_q), .in_wait(in_wait), .set_vec(set_vec)
);

// File: tb/test_sdc_cmd_path.sv
module test_sdc_cmd_path;
  logic clk = 1'b0;
  logic rst_n, reg_we, cmd_in, d0_in, cmd_out, cmd_oe;
  logic [2:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  sdc_cmd_path i_sdc_cmd_path (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_out(cmd_out),
    .cmd_oe(cmd_oe), .cmd_in(cmd_in), .d0_in(d0_in)
  );

  // CRC7 by long division of d * x^7 by x^7 + x^3 + 1
  function automatic bit [6:0] div_crc(input bit [39:0] d);
    bit [46:0] v;
    v = {d, 7'b0};
    for (int i = 46; i >= 7; i--)
      if (v[i]) v = v ^ (47'(8'h89) << (i - 7));
    return v[6:0];
  endfunction

  task automatic ck(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  // start a command and capture its 48 line bits
  task automatic issue(input logic [31:0] cv, input logic [31:0] arg,
                       output logic [47:0] got, output int oe_bad,
                       output logic [31:0] s10, output logic [31:0] s47);
    logic [31:0] s;
    wr(3'd1, 32'd0);
    wr(3'd7, 32'hFFFF_FFFF);
    wr(3'd0, arg);
    wr(3'd1, cv);
    oe_bad = 0;
    got = '0;
    s10 = '0;
    s47 = '0;
    for (int i = 0; i < 48; i++) begin
      got = {got[46:0], cmd_out};
      if (!cmd_oe) oe_bad++;
      rd(3'd7, s);
      if (i == 10) s10 = s;
      if (i == 47) s47 = s;
      @(negedge clk);
    end
  endtask

  task automatic send(input logic [135:0] f, input int n);
    for (int i = 0; i < n; i++) begin
      cmd_in = f[n-1-i];
      @(negedge clk);
    end
    cmd_in = 1'b1;
  endtask

  function automatic logic [47:0] short_rsp(input logic [5:0] idx, input logic [31:0] p,
                                            input bit spoil);
    logic [6:0] c;
    c = div_crc({2'b00, idx, p});
    if (spoil) c = c ^ 7'h01;
    return {2'b00, idx, p, c, 1'b1};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] s, s10, s47, arg, w;
    logic [47:0] got, rf;
    logic [135:0] lf;
    logic [127:0] lc;
    int oe_bad;

    rst_n = 1'b0; reg_we = 1'b0; reg_addr = 3'd0; reg_wdata = '0;
    cmd_in = 1'b1; d0_in = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), s);
      ck("R1 register reads zero", s, 0);
    end
    ck("R1 line idle", {cmd_oe, cmd_out}, 2'b01);

    // R2, R3, R11, R12: sweep of every index, no reply
    for (int idx = 0; idx < 64; idx++) begin
      logic [31:0] cv;
      arg = 32'(idx) * 32'h9E37_79B9 ^ 32'h5A5A_0000;
      cv  = 32'h1000 | 32'(idx) | ((idx % 2 == 1) ? 32'h80 : 32'h0);
      issue(cv, arg, got, oe_bad, s10, s47);
      ck("R2 frame", got, {2'b01, 6'(idx), arg, div_crc({2'b01, 6'(idx), arg}), 1'b1});
      ck("R2 drive enable held", oe_bad, 0);
      ck("R11 active during send", s10[13], 1);
      ck("R3 sent not early", s47[7], 0);
      rd(3'd7, s);
      ck("R3 sent flag due", {cmd_oe, s[13], s[7]}, 3'b001);
      rd(3'd1, s);
      ck("R12 command readback", s, cv);
    end

    // R4: no reply within the window
    issue(32'h1100 | 32'd5, 32'h1234_5678, got, oe_bad, s10, s47);
    for (int k = 1; k <= 64; k++) begin
      @(negedge clk);
      rd(3'd7, s);
      if (k == 63) ck("R4 timeout not early", {s[13], s[2]}, 2'b10);
      if (k == 64) ck("R4 timeout due", {s[13], s[2]}, 2'b01);
    end

    // R5: short reply, CRC good
    issue(32'h1100 | 32'd17, 32'hCAFE_0001, got, oe_bad, s10, s47);
    rf = short_rsp(6'd17, 32'hDEAD_BEEF, 1'b0);
    send(136'(rf), 48);
    rd(3'd7, s);
    ck("R5 flag not early", s & 32'h41, 32'h0);
    @(negedge clk);
    rd(3'd7, s);
    ck("R5 reply good", s & 32'h2041, 32'h40);
    rd(3'd2, s);
    ck("R5 response word", s, 32'hDEAD_BEEF);

    // R5: short reply, CRC bad
    issue(32'h1100 | 32'd18, 32'hCAFE_0002, got, oe_bad, s10, s47);
    rf = short_rsp(6'd18, 32'h0BAD_C0DE, 1'b1);
    send(136'(rf), 48);
    @(negedge clk);
    rd(3'd7, s);
    ck("R5 reply crc fail", s & 32'h41, 32'h01);

    // R6: short reply without check
    issue(32'h1200 | 32'd19, 32'hCAFE_0003, got, oe_bad, s10, s47);
    rf = short_rsp(6'd19, 32'h1357_9BDF, 1'b1);
    send(136'(rf), 48);
    @(negedge clk);
    rd(3'd7, s);
    ck("R6 unchecked reply", s & 32'h41, 32'h40);
    rd(3'd2, s);
    ck("R6 response word", s, 32'h1357_9BDF);

    // R7: long reply
    lc = {32'h0102_0304, 32'hA5A5_5A5A, 32'hFFFF_0000, 32'h8765_4321 | 32'h1};
    lf = {8'h3F, lc};
    issue(32'h1300 | 32'd2, 32'h0, got, oe_bad, s10, s47);
    send(lf, 136);
    rd(3'd7, s);
    ck("R7 flag not early", s[6], 0);
    @(negedge clk);
    rd(3'd7, s);
    ck("R7 long reply flag", s & 32'h41, 32'h40);
    for (int k = 0; k < 4; k++) begin
      rd(3'(2 + k), w);
      ck("R7 long reply word", w, lc[127-32*k -: 32]);
    end

    // R8: busy then release
    wr(3'd6, 32'd50);
    d0_in = 1'b0;
    issue(32'h1100 | 32'd7, 32'h0, got, oe_bad, s10, s47);
    send(136'(short_rsp(6'd7, 32'h0000_0900, 1'b0)), 48);
    @(negedge clk);
    rd(3'd7, s);
    ck("R8 busy shown", {s[20], s[6]}, 2'b11);
    repeat (5) @(negedge clk);
    d0_in = 1'b1;
    @(negedge clk);
    rd(3'd7, s);
    ck("R8 busy end", s & 32'h0030_2008, 32'h0020_0000);

    // R9: busy outlasts the data timer
    wr(3'd6, 32'd10);
    d0_in = 1'b0;
    issue(32'h1100 | 32'd28, 32'h0, got, oe_bad, s10, s47);
    send(136'(short_rsp(6'd28, 32'h0000_0800, 1'b0)), 48);
    @(negedge clk);
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      rd(3'd7, s);
      if (k == 9)  ck("R9 timer not early", {s[20], s[3]}, 2'b10);
      if (k == 10) ck("R9 data timeout", {s[21], s[20], s[3]}, 3'b001);
    end

    // R8: data-transfer commands skip the busy wait
    issue(32'h1140 | 32'd17, 32'h0, got, oe_bad, s10, s47);
    send(136'(short_rsp(6'd17, 32'h0000_0001, 1'b0)), 48);
    @(negedge clk);
    rd(3'd7, s);
    ck("R8 no busy with data bit", {s[20], s[13], s[6]}, 3'b001);
    d0_in = 1'b1;

    // R10: write-one-to-clear
    wr(3'd7, 32'h0000_0001);
    rd(3'd7, s);
    ck("R10 other flag kept", s[6], 1);
    wr(3'd7, 32'h0000_0040);
    rd(3'd7, s);
    ck("R10 flag cleared", s[6], 0);

    // R12: re-arm rule and abort
    wr(3'd1, 32'h1000 | 32'd9);
    rd(3'd1, s);
    ck("R12 nonzero write ignored", s, 32'h1140 | 32'd17);
    oe_bad = 0;
    repeat (3) begin
      @(negedge clk);
      if (cmd_oe) oe_bad++;
    end
    ck("R12 nothing sent", oe_bad, 0);
    wr(3'd1, 32'd0);
    rd(3'd1, s);
    ck("R12 zero write clears", s, 32'd0);
    wr(3'd0, 32'h5555_AAAA);
    wr(3'd1, 32'h1000 | 32'd3);
    repeat (5) @(negedge clk);
    ck("R12 sending before abort", cmd_oe, 1);
    wr(3'd1, 32'd0);
    rd(3'd7, s);
    ck("R12 abort releases line", {cmd_oe, cmd_out, s[13]}, 3'b010);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule